// File: doc/BRIEF.md
# Rotating Register Loop Controller

This block runs the counted-loop branch of a modulo-scheduled loop. It holds a 64-bit trip counter and a small drain counter. It also keeps two rotating bases, one for the upper general registers and one for the upper predicate registers. It stores the rotating predicate bits and renames virtual register numbers to physical ones. Software first loads the counters, which also sets the first rotating predicate. Each loop branch then rotates the register windows by one. In the same event it shifts a fresh stage-enable bit into the predicate window, so a single kernel body fills and drains the pipeline. No separate prologue or epilogue code is needed.

When a branch event arrives, the block reports at once whether it is taken or falls through. The counters, bases and stage bit update on the next clock edge. The rename ports are purely combinational and are read by the decode logic. General registers 32 to 127 rotate as a ring of 96 entries. Predicates 16 to 63 rotate as a ring of 48 entries. Lower numbers pass through unchanged.

Top module: `rot_loop_ctrl`

## Requirements
- R1: After reset both rotating bases are zero, every rotating predicate reads false, and both counters are zero, so a branch event falls through.
- R2: A general register number v in 32..127 maps to 32 + ((v - 32 + gbase) mod 96). Here gbase is the general rotating base.
- R3: General register numbers 0..31 come out unchanged on the physical port.
- R4: A predicate number v in 16..63 maps to 16 + ((v - 16 + pbase) mod 48). Numbers 0..15 pass through unchanged. The predicate read port returns the stored bit of the mapped rotating slot, and returns 0 for numbers 0..15.
- R5: A load pulse writes the trip count into the loop counter and the drain length into the epilogue counter. It also sets the predicate currently at virtual number 16 to true.
- R6: A branch event with a nonzero loop counter is taken. It decrements the loop counter, decrements both bases modulo their ring sizes (0 wraps to 95 and 47), and writes true into the new virtual predicate 16.
- R7: A branch event with a zero loop counter and a nonzero epilogue counter is taken. It decrements the epilogue counter, rotates both bases, and writes false into the new virtual predicate 16.
- R8: A branch event with both counters zero raises the fall-through output. The bases, counters and predicates do not change.
- R9: After a taken branch, every rotating predicate previously at virtual number n (16..62) reads at virtual number n+1. After a load with trip count L and k taken branches, virtual predicate 16+j for j < k is true exactly when k - j <= L.
- R10: A clear pulse sets both rotating bases to zero. The counters and the stored predicates are left as they were.
- R11: A branch event in the same cycle as clear or load is ignored: neither taken nor fall-through is raised, and nothing rotates because of it. A loaded loop therefore takes exactly trip + drain branches before it falls through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Reset both rotating bases to zero |
| load | input | 1 | Load counters and set virtual predicate 16 |
| trip_count | input | 64 | Value for the loop counter |
| drain_count | input | 6 | Value for the epilogue counter |
| loop_br | input | 1 | Counted-loop branch event |
| taken | output | 1 | Branch event is taken (rotation happens) |
| fall_thru | output | 1 | Branch event falls through |
| gr_virt | input | 7 | Virtual general register number |
| gr_phys | output | 7 | Physical general register number |
| pr_virt | input | 6 | Virtual predicate number |
| pr_phys | output | 6 | Physical predicate number |
| pr_val | output | 1 | Stored value of the addressed rotating predicate |

## Verification
The bench sweeps each pair of trip count 0..3 and drain length 0..3. At every step it compares the taken or fall-through decision and the full stage-predicate window with a pattern computed from the step number. A design that wrote the stage bit at the old base would show the pattern shifted by one slot, and a design that wrote the stage bit before rotating would place it at virtual number 17 instead of 16. A run of 100 rotations crosses the 95-to-0 and 47-to-0 boundaries of both rings, which catches a base that wraps to a power of two instead of the ring size. Further checks cover branches issued together with clear or load, repeated fall-through with no rotation, and the full 64-bit trip count.

// File: rtl/rot_loop_pkg.sv
package rot_loop_pkg;

  // Decrement a rotating base modulo the ring size.
  function automatic int unsigned rot_dec(input int unsigned base, input int unsigned size);
    if (base == 0) return size - 1;
    return base - 1;
  endfunction

  // Map a virtual register number to its physical number.
  // Numbers below the ring start pass through unchanged.
  function automatic int unsigned rot_rename(input int unsigned virt, input int unsigned first,
                                             input int unsigned size, input int unsigned base);
    int unsigned sum;
    if (virt < first) return virt;
    sum = (virt - first) + base;
    if (sum >= size) sum = sum - size;
    return first + sum;
  endfunction

endpackage

// File: rtl/rlc_rot_base.sv
module rlc_rot_base
  import rot_loop_pkg::*;
#(
  parameter int SIZE = 96,
  localparam int W = $clog2(SIZE)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] base
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) base <= '0;
    else if (step)     base <= W'(rot_dec(32'(base), SIZE));
  end

  assert_in_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(base) < SIZE);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && base == '0) |=> (32'(base) == SIZE - 1));

endmodule

// File: rtl/rlc_counts.sv
module rlc_counts #(
  parameter int LC_W = 64,
  parameter int EC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LC_W-1:0] trip,
  input  logic [EC_W-1:0] drain,
  input  logic            br,
  output logic            taken,
  output logic            fall,
  output logic            stage_bit
);

  logic [LC_W-1:0] lc_q;
  logic [EC_W-1:0] ec_q;
  logic            lc_live;
  logic            ec_live;

  assign lc_live   = (lc_q != '0);
  assign ec_live   = (ec_q != '0);
  assign taken     = br && (lc_live || ec_live);
  assign fall      = br && !lc_live && !ec_live;
  assign stage_bit = lc_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_q <= '0;
      ec_q <= '0;
    end else if (load) begin
      lc_q <= trip;
      ec_q <= drain;
    end else if (br) begin
      if (lc_live)      lc_q <= lc_q - LC_W'(1);
      else if (ec_live) ec_q <= ec_q - EC_W'(1);
    end
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken && fall));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lc_q == $past(trip) && ec_q == $past(drain)));

  assert_lc_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (br && !load && lc_live) |=> (lc_q == $past(lc_q) - LC_W'(1) && $stable(ec_q)));

  assert_ec_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br && !load && !lc_live && ec_live) |=> (lc_q == '0 && ec_q == $past(ec_q) - EC_W'(1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !load) |=> ($stable(lc_q) && $stable(ec_q)));

endmodule

// File: rtl/rlc_pred_ring.sv
module rlc_pred_ring
  import rot_loop_pkg::*;
#(
  parameter int SIZE = 48,
  localparam int W = $clog2(SIZE)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] base,
  input  logic         set_first,
  input  logic         step,
  input  logic         stage_bit,
  input  logic [W-1:0] rd_slot,
  output logic         rd_bit
);

  logic [SIZE-1:0] ring_q;
  logic [W-1:0]    wr_slot;

  // The stage bit lands at the slot that virtual 16 names after rotation.
  assign wr_slot = step ? W'(rot_dec(32'(base), SIZE)) : base;
  assign rd_bit  = ring_q[rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n)         ring_q <= '0;
    else if (set_first) ring_q[wr_slot] <= 1'b1;
    else if (step)      ring_q[wr_slot] <= stage_bit;
  end

  assert_shift_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !set_first) |=> (ring_q[$past(base)] == $past(ring_q[base])));

  assert_stage_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !set_first) |=> (ring_q[base] == $past(stage_bit)));

  assert_first_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_first |=> ring_q[$past(base)]);

endmodule

// File: rtl/rot_loop_ctrl.sv
module rot_loop_ctrl
  import rot_loop_pkg::*;
#(
  parameter int GR_COUNT = 128,
  parameter int GR_FIRST = 32,
  parameter int PR_COUNT = 64,
  parameter int PR_FIRST = 16,
  parameter int LC_W     = 64,
  parameter int EC_W     = 6,
  localparam int GR_IW   = $clog2(GR_COUNT),
  localparam int PR_IW   = $clog2(PR_COUNT),
  localparam int GR_RING = GR_COUNT - GR_FIRST,
  localparam int PR_RING = PR_COUNT - PR_FIRST,
  localparam int GB_W    = $clog2(GR_RING),
  localparam int PB_W    = $clog2(PR_RING)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [LC_W-1:0]  trip_count,
  input  logic [EC_W-1:0]  drain_count,
  input  logic             loop_br,
  output logic             taken,
  output logic             fall_thru,
  input  logic [GR_IW-1:0] gr_virt,
  output logic [GR_IW-1:0] gr_phys,
  input  logic [PR_IW-1:0] pr_virt,
  output logic [PR_IW-1:0] pr_phys,
  output logic             pr_val
);

  logic            br_q;
  logic            rotate;
  logic            stage_bit;
  logic [GB_W-1:0] gr_base;
  logic [PB_W-1:0] pr_base;
  logic [PB_W-1:0] pr_slot;
  logic            pr_in_ring;
  logic            ring_bit;

  // A branch that coincides with clear or load is dropped.
  assign br_q   = loop_br && !clear && !load;
  assign rotate = taken;

  rlc_counts #(.LC_W(LC_W), .EC_W(EC_W)) u_counts (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .trip      (trip_count),
    .drain     (drain_count),
    .br        (br_q),
    .taken     (taken),
    .fall      (fall_thru),
    .stage_bit (stage_bit)
  );

  rlc_rot_base #(.SIZE(GR_RING)) u_gr_base (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clear),
    .step  (rotate),
    .base  (gr_base)
  );

  rlc_rot_base #(.SIZE(PR_RING)) u_pr_base (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clear),
    .step  (rotate),
    .base  (pr_base)
  );

  rlc_pred_ring #(.SIZE(PR_RING)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (pr_base),
    .set_first (load),
    .step      (rotate),
    .stage_bit (stage_bit),
    .rd_slot   (pr_slot),
    .rd_bit    (ring_bit)
  );

  assign gr_phys    = GR_IW'(rot_rename(32'(gr_virt), GR_FIRST, GR_RING, 32'(gr_base)));
  assign pr_phys    = PR_IW'(rot_rename(32'(pr_virt), PR_FIRST, PR_RING, 32'(pr_base)));
  assign pr_in_ring = (32'(pr_virt) >= PR_FIRST);
  assign pr_slot    = pr_in_ring ? PB_W'(32'(pr_phys) - PR_FIRST) : '0;
  assign pr_val     = pr_in_ring && ring_bit;

  assert_no_rot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_thru |=> ($stable(gr_base) && $stable(pr_base)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (gr_base == '0 && pr_base == '0));

  assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || load) |-> (!taken && !fall_thru));

  assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && $past(gr_base) == gr_base) |=> (gr_base != $past(gr_base)));

  assert_pass_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gr_virt) < GR_FIRST) |-> (gr_phys == gr_virt));

endmodule

// File: tb/tb_rot_loop_ctrl.sv
`timescale 1ns/1ps
module tb_rot_loop_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        load = 1'b0;
  logic [63:0] trip_count = '0;
  logic [5:0]  drain_count = '0;
  logic        loop_br = 1'b0;
  logic        taken;
  logic        fall_thru;
  logic [6:0]  gr_virt = '0;
  logic [6:0]  gr_phys;
  logic [5:0]  pr_virt = '0;
  logic [5:0]  pr_phys;
  logic        pr_val;

  int n_checks = 0;
  int n_fail = 0;
  int rot_k = 0;   // rotations since the last clear

  always #2.5 clk = ~clk;

  rot_loop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load),
    .trip_count(trip_count), .drain_count(drain_count), .loop_br(loop_br),
    .taken(taken), .fall_thru(fall_thru),
    .gr_virt(gr_virt), .gr_phys(gr_phys),
    .pr_virt(pr_virt), .pr_phys(pr_phys), .pr_val(pr_val)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected physical numbers, written as a subtraction of the rotation count.
  function automatic int exp_gr(input int v, input int k);
    if (v < 32) return v;
    return 32 + ((v - 32) + 96 * 4 - (k % 96)) % 96;
  endfunction

  function automatic int exp_pr(input int v, input int k);
    if (v < 16) return v;
    return 16 + ((v - 16) + 48 * 4 - (k % 48)) % 48;
  endfunction

  task automatic sweep_rename(input string tag);
    for (int v = 0; v < 128; v++) begin
      gr_virt = 7'(v);
      #0.01;
      check(v < 32 ? "R3" : {"R2 ", tag}, gr_phys, exp_gr(v, rot_k));
    end
    for (int v = 0; v < 64; v++) begin
      pr_virt = 6'(v);
      #0.01;
      check({"R4 ", tag}, pr_phys, exp_pr(v, rot_k));
    end
  endtask

  // Stage window after a load with trip L and k taken branches (R9).
  task automatic check_window(input int L, input int k);
    for (int j = 0; j < 48; j++) begin
      if (j <= k) begin
        pr_virt = 6'(16 + j);
        #0.01;
        if (j == k) check("R5 first predicate", pr_val, 1);
        else        check("R9 stage window", pr_val, (k - j) <= L);
      end
    end
  endtask

  // One branch event: check the decision before the edge, update after.
  task automatic branch(input int exp_taken);
    @(negedge clk);
    loop_br = 1'b1;
    #0.5;
    check("R6/R7 taken", taken, exp_taken);
    check("R8 fall_thru", fall_thru, !exp_taken);
    @(posedge clk);
    #0.5;
    loop_br = 1'b0;
    if (exp_taken != 0) rot_k++;
  endtask

  task automatic do_clear(input logic with_br);
    @(negedge clk);
    clear = 1'b1;
    loop_br = with_br;
    #0.5;
    if (with_br) begin
      check("R11 clear+br taken", taken, 0);
      check("R11 clear+br fall", fall_thru, 0);
    end
    @(posedge clk);
    #0.5;
    clear = 1'b0;
    loop_br = 1'b0;
    rot_k = 0;
  endtask

  task automatic do_load(input longint unsigned L, input int E, input logic with_br);
    @(negedge clk);
    load = 1'b1;
    trip_count = 64'(L);
    drain_count = 6'(E);
    loop_br = with_br;
    #0.5;
    if (with_br) begin
      check("R11 load+br taken", taken, 0);
      check("R11 load+br fall", fall_thru, 0);
    end
    @(posedge clk);
    #0.5;
    load = 1'b0;
    loop_br = 1'b0;
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    rst_n = 1'b1;
    // R1: reset state
    for (int v = 16; v < 64; v++) begin
      pr_virt = 6'(v);
      #0.01;
      check("R1 predicate cleared", pr_val, 0);
    end
    for (int v = 0; v < 16; v++) begin
      pr_virt = 6'(v);
      #0.01;
      check("R4 static predicate reads 0", pr_val, 0);
    end
    sweep_rename("reset");
    branch(0);  // R1: counters zero, falls through

    // Trip and drain sweep (R5, R6, R7, R8, R9, R10, R11)
    for (int L = 0; L < 4; L++) begin
      for (int E = 0; E < 4; E++) begin
        do_clear(1'b0);
        do_load(64'(L), E, (L == 2));
        check_window(L, 0);
        for (int i = 0; i < L + E; i++) begin
          branch(1);
          check_window(L, i + 1);
        end
        branch(0);  // R11: exactly L+E taken
        check_window(L, L + E);
        sweep_rename("after loop");
      end
    end

    // R8: repeated fall-through does not rotate
    branch(0);
    sweep_rename("R8 no rotate");

    // R10: clear resets the bases but keeps predicates, even with a branch
    do_clear(1'b0);
    do_load(64'd3, 0, 1'b0);
    branch(1);
    branch(1);
    do_clear(1'b1);
    sweep_rename("R10 clear");
    pr_virt = 6'(16 + 46);   // the slot of virtual 16 before the clear
    #0.01;
    check("R10 predicate kept", pr_val, 1);

    // Long run across both ring boundaries
    do_clear(1'b0);
    do_load(64'd100, 0, 1'b0);
    for (int i = 0; i < 100; i++) branch(1);
    sweep_rename("wrap");
    check_window(100, 100);
    branch(0);

    // Full-width trip count
    do_clear(1'b0);
    do_load(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0);
    branch(1);
    branch(1);
    sweep_rename("wide count");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule